// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block decides which of eight interrupt lines, if any, should be offered to the processor. It takes the raw request lines, a mask, the set of lines already being serviced and a rotation offset, and it offers a line only when that line outranks every line in service. Priority is counted from the rotation offset upward, with wrap-around, so the line at the offset is the most urgent. Software can move the offset to share service fairly among the lines.

In a two-level cascade the primary controller sees the secondary controller's output on line 2. A nesting option lets the primary ignore its own in-service bit for that line. A secondary request of higher rank can then reach the processor even while an earlier secondary interrupt is still being serviced. The request, mask and in-service registers are held outside this block, and so is the cascade wiring.

The result is registered. The interrupt flag follows the inputs one clock later. The line number does not change while the flag stays high, so an acknowledge cycle can sample it safely.

Top module: `rot_prio_resolver`

## Requirements
- R1: While `rst_n` is low, both `irq_o` and `line_o` are 0 after the next clock edge.
- R2: A line whose bit in `mask_i` is 1 never wins. If no request is left after masking, `irq_o` is 0.
- R3: A line's rank is its distance counted upward from `rot_i`, modulo 8. Rank 0 is the most urgent. Among unmasked requests, the lowest rank wins.
- R4: Lines in service are ranked the same way. A winner is offered only if its rank is strictly below the lowest in-service rank, so equal rank is not offered.
- R5: When `nest_en_i` is 1 and `primary_i` is 1, bit 2 of `insvc_i` is left out of the in-service ranking. In every other case bit 2 counts.
- R6: If no line qualifies, `irq_o` is 0 after the next clock edge.
- R7: `irq_o` and `line_o` reflect the inputs seen at the previous rising clock edge. The offered line number is the winner's bit index.
- R8: While `irq_o` stays high, `line_o` does not change. If the winner changes while `irq_o` is high, `irq_o` drops for one cycle. The new line is then offered with `irq_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 8 | Request lines, bit n is line n |
| mask_i | input | 8 | Mask, 1 blocks the line |
| insvc_i | input | 8 | Lines currently in service |
| rot_i | input | 3 | Rotation offset: the line at this index is most urgent |
| nest_en_i | input | 1 | Nesting option: ignore in-service line 2 on the primary |
| primary_i | input | 1 | 1 when this instance is the primary controller |
| irq_o | output | 1 | Registered interrupt offer |
| line_o | output | 3 | Offered line number, stable while `irq_o` is high |

## Verification
The resolver is driven with these input patterns:
- A single request, to show latency and line encoding.
- Two requests under different rotation offsets, including wrap-around at offset 7, to tell rotated ranking apart from fixed ranking.
- Masked and fully masked sets, to separate the mask from the request.
- In-service sets of lower, equal and higher rank, to show the strict comparison.

The nesting option is tried under three settings with line 2 both requested and in service: role primary with the option on, role secondary, and the option off. Only the first of these may offer the line. A higher-rank request that arrives while a line is already offered shows the one-cycle drop and the re-offer.

// File: rtl/rpr_pkg.sv
// Package: shared defaults for the rotating priority resolver.
// Assumes the line count is a power of two so that the offset wraps by truncation.
package rpr_pkg;
    localparam int RPR_LINES_DFLT   = 8;
    localparam int RPR_CASCADE_DFLT = 2;

    // Returns 1 when v is a nonzero power of two
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction
endpackage

// File: rtl/rpr_rank.sv
// Module: rpr_rank
// Finds the rank of the most urgent set bit of vec_i, counting from off_i
// upward with wrap-around. The output rank N means the vector is empty.
// Assumes N is a power of two and W = log2(N).
module rpr_rank #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec_i,
    input  logic [W-1:0] off_i,
    output logic [W:0]   rank_o
);
    localparam logic [W:0] NONE = (W+1)'(N);

    logic [N-1:0] rot_vec;

    // Rotate the vector so that bit 0 is the line at the offset
    for (genvar p = 0; p < N; p++) begin : g_rot
        assign rot_vec[p] = vec_i[W'(p) + off_i];
    end

    // Priority-encode the rotated vector, lowest index first
    always_comb begin
        rank_o = NONE;
        for (int p = N - 1; p >= 0; p--) begin
            if (rot_vec[p]) rank_o = (W+1)'(p);
        end
    end
endmodule

// File: rtl/rpr_nest_filter.sv
// Module: rpr_nest_filter
// Removes the cascade line from the in-service set when the nesting option
// is on and this instance is the primary. Otherwise the set passes unchanged.
module rpr_nest_filter #(
    parameter int N       = 8,
    parameter int CASCADE = 2
) (
    input  logic [N-1:0] insvc_i,
    input  logic         nest_en_i,
    input  logic         primary_i,
    output logic [N-1:0] insvc_o
);
    localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE;

    // Clear the cascade bit only on a primary that has nesting on
    always_comb begin
        insvc_o = insvc_i;
        if (nest_en_i && primary_i) insvc_o = insvc_i & ~CASC_BIT;
    end
endmodule

// File: rtl/rpr_present.sv
// Module: rpr_present
// Registers the offer. The line number is captured when an offer starts and
// is held while the offer stays high. A changed winner drops the offer for
// one cycle so that the new line is loaded on a fresh rising offer.
module rpr_present #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cand_valid_i,
    input  logic [W-1:0] cand_line_i,
    output logic         irq_o,
    output logic [W-1:0] line_o
);
    logic same_line;

    // Detect whether the current winner matches the held line
    always_comb same_line = (cand_line_i == line_o);

    // Update the offer flag and the held line each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            line_o <= '0;
        end else begin
            irq_o <= cand_valid_i && (!irq_o || same_line);
            if (cand_valid_i && !irq_o) line_o <= cand_line_i;
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
// Module: rot_prio_resolver (top)
// Picks the most urgent unmasked request under a rotating priority. It offers
// the request only when it outranks every line in service, with the nesting
// exemption applied to the cascade line. The offer is registered.
// Assumes LINES is a power of two.
module rot_prio_resolver #(
    parameter int LINES   = rpr_pkg::RPR_LINES_DFLT,
    parameter int CASCADE = rpr_pkg::RPR_CASCADE_DFLT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LINES-1:0]           req_i,
    input  logic [LINES-1:0]           mask_i,
    input  logic [LINES-1:0]           insvc_i,
    input  logic [$clog2(LINES)-1:0]   rot_i,
    input  logic                       nest_en_i,
    input  logic                       primary_i,
    output logic                       irq_o,
    output logic [$clog2(LINES)-1:0]   line_o
);
    localparam int W = $clog2(LINES);

    initial begin
        if (!rpr_pkg::is_pow2(LINES)) $error("LINES must be a power of two");
    end

    logic [LINES-1:0] cand;
    logic [LINES-1:0] insvc_eff;
    logic [W:0]       req_rank;
    logic [W:0]       cur_rank;
    logic             win_valid;
    logic [W-1:0]     win_line;

    // Candidate set: requested and not masked
    always_comb cand = req_i & ~mask_i;

    rpr_nest_filter #(.N(LINES), .CASCADE(CASCADE)) u_nest (
        .insvc_i   (insvc_i),
        .nest_en_i (nest_en_i),
        .primary_i (primary_i),
        .insvc_o   (insvc_eff)
    );

    rpr_rank #(.N(LINES), .W(W)) u_req_rank (
        .vec_i  (cand),
        .off_i  (rot_i),
        .rank_o (req_rank)
    );

    rpr_rank #(.N(LINES), .W(W)) u_cur_rank (
        .vec_i  (insvc_eff),
        .off_i  (rot_i),
        .rank_o (cur_rank)
    );

    // Strict comparison against the in-service rank, then map rank to line
    always_comb begin
        win_valid = (req_rank < cur_rank);
        win_line  = req_rank[W-1:0] + rot_i;
    end

    rpr_present #(.W(W)) u_present (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_valid_i (win_valid),
        .cand_line_i  (win_line),
        .irq_o        (irq_o),
        .line_o       (line_o)
    );
endmodule

// File: rtl/rpr_checker.sv
// Module: rpr_checker
// Temporal checks on the resolver ports, bound into rot_prio_resolver.
module rpr_checker #(
    parameter int LINES   = 8,
    parameter int CASCADE = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [LINES-1:0]         req_i,
    input logic [LINES-1:0]         mask_i,
    input logic [LINES-1:0]         insvc_i,
    input logic                     nest_en_i,
    input logic                     primary_i,
    input logic                     irq_o,
    input logic [$clog2(LINES)-1:0] line_o
);
    logic [LINES-1:0] req_d, mask_d, insvc_d;
    logic             exempt_d;

    // Keep the inputs of the previous edge for comparison with the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d    <= '0;
            mask_d   <= '1;
            insvc_d  <= '0;
            exempt_d <= 1'b0;
        end else begin
            req_d    <= req_i;
            mask_d   <= mask_i;
            insvc_d  <= insvc_i;
            exempt_d <= nest_en_i && primary_i;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && line_o == '0));

    // R2
    offered_is_unmasked_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_d[line_o] && !mask_d[line_o]));

    // R6
    no_candidate_no_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & ~mask_i) == '0) |=> !irq_o);

    // R4
    not_already_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(exempt_d && int'(line_o) == CASCADE)) |-> !insvc_d[line_o]);

    // R8
    line_held_while_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> (!irq_o || $stable(line_o)));
endmodule

bind rot_prio_resolver rpr_checker #(.LINES(LINES), .CASCADE(CASCADE)) u_rpr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .mask_i    (mask_i),
    .insvc_i   (insvc_i),
    .nest_en_i (nest_en_i),
    .primary_i (primary_i),
    .irq_o     (irq_o),
    .line_o    (line_o)
);

// File: tb/test_rot_prio_resolver.sv
module test_rot_prio_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, mask = '0, insvc = '0;
    logic [2:0] rot = '0;
    logic       nest = 1'b0, prim = 1'b0;
    logic       irq;
    logic [2:0] line;

    int checks = 0;
    int fails  = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    // Model state, derived from R7 and R8
    logic       m_irq = 1'b0;
    logic [2:0] m_line = '0;

    always #5 clk = ~clk;

    rot_prio_resolver i_rot_prio_resolver (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .insvc_i(insvc),
        .rot_i(rot), .nest_en_i(nest), .primary_i(prim), .irq_o(irq), .line_o(line)
    );

    // Winner by the rules of R2 to R5, returned as {valid, line}
    function automatic logic [3:0] pick(input logic [7:0] r, input logic [7:0] m,
                                        input logic [7:0] s, input logic [2:0] o,
                                        input logic n, input logic p);
        int rp = 8, cp = 8;
        logic [7:0] c = r & ~m;
        logic [7:0] se = s;
        if (n && p) se[2] = 1'b0;
        for (int k = 7; k >= 0; k--) begin
            if (c[(k + o) % 8])  rp = k;
            if (se[(k + o) % 8]) cp = k;
        end
        if (rp < cp) return {1'b1, 3'((rp + o) % 8)};
        return 4'b0000;
    endfunction

    // Driver: apply inputs, predict the next registered outputs, queue them
    task automatic step(input logic [7:0] r, input logic [7:0] m, input logic [7:0] s,
                        input logic [2:0] o, input logic n, input logic p, input string tag);
        logic [3:0] w;
        @(negedge clk);
        req = r; mask = m; insvc = s; rot = o; nest = n; prim = p;
        w = pick(r, m, s, o, n, p);
        if (w[3] && !m_irq) m_line = w[2:0];
        m_irq = w[3] && (!m_irq || w[2:0] == m_line);
        #1;
        exp_q.push_back({m_irq, m_line});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare outputs with the oldest expectation
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({irq, line} !== e) begin
                fails++;
                $display("FAIL %s: got irq=%0b line=%0d, expected irq=%0b line=%0d",
                         t, irq, line, e[3], e[2:0]);
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        req = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq !== 1'b0 || line !== 3'd0) begin
            fails++;
            $display("FAIL R1: got irq=%0b line=%0d, expected irq=0 line=0", irq, line);
        end
        rst_n = 1'b1;
        req = '0;
        // R7 single request, one-cycle latency
        step(8'h20, 8'h00, 8'h00, 3'd0, 0, 0, "R7");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        // R3 rotation: fixed order, wrap at offset 7, offset 3
        step(8'h81, 8'h00, 8'h00, 3'd0, 0, 0, "R3");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        step(8'h81, 8'h00, 8'h00, 3'd7, 0, 0, "R3");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        step(8'h42, 8'h00, 8'h00, 3'd3, 0, 0, "R3");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        // R2 masking
        step(8'h0C, 8'h04, 8'h00, 3'd0, 0, 0, "R2");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        step(8'h0C, 8'h0C, 8'h00, 3'd0, 0, 0, "R2");
        // R4 in-service comparison: equal, higher, lower rank
        step(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
        step(8'h02, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        step(8'h20, 8'h00, 8'h08, 3'd0, 0, 0, "R4");
        step(8'h20, 8'h00, 8'h08, 3'd4, 0, 0, "R4");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        // R5 nesting exemption on line 2
        step(8'h04, 8'h00, 8'h04, 3'd0, 1, 1, "R5");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        step(8'h04, 8'h00, 8'h04, 3'd0, 1, 0, "R5");
        step(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, "R5");
        step(8'h08, 8'h00, 8'h04, 3'd0, 1, 1, "R5");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        // R8 hold, then a higher winner: drop one cycle, then re-offer
        step(8'h10, 8'h00, 8'h00, 3'd0, 0, 0, "R8");
        step(8'h10, 8'h00, 8'h00, 3'd0, 0, 0, "R8");
        step(8'h12, 8'h00, 8'h00, 3'd0, 0, 0, "R8");
        step(8'h12, 8'h00, 8'h00, 3'd0, 0, 0, "R8");
        step(8'h12, 8'h00, 8'h00, 3'd0, 0, 0, "R8");
        step(8'h00, 8'h00, 8'h00, 3'd0, 0, 0, "R6");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule